// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control core of a small accumulator machine. It runs every instruction as a fixed chain of subcycles. Fetch comes first. An indirect subcycle follows when the instruction word asks for one. Then comes an execute step, and last an instruction-end boundary where an interrupt may be entered. Each subcycle is a short list of register transfers among the program counter (PC), the memory address register (MAR), the memory buffer register (MBR), the instruction register (IR) and the accumulator (ACC). Each transfer takes one clock cycle.

The block reaches memory through one single-port interface. That interface has an address, write data, read data, a read strobe, a write strobe and a ready input. A strobe stays high until the memory answers with ready. The datapath always drives the address from the MAR and the write data from the MBR. Only two operations touch the accumulator: load and add. Interrupt entry saves the return address at a fixed location and then continues at a fixed handler address. Both addresses are parameters.

Top module: `icyc_seq`

## Requirements
- R1: While reset is held, and after it is released, PC, ACC and the interrupt-enable bit are 0 and neither strobe is high. The first memory access after reset is a read at address 0.
- R2: Fetch reads memory at the current PC. It copies the returned word through the MBR into the IR. PC steps by one in the fetch, so at the instruction-end pulse PC shows the address that follows the fetched word.
- R3: The instruction word has the opcode in bits [15:12], the indirect flag in bit [11] and an 11-bit address field in bits [10:0]. When bit 11 is set, one extra read takes place at the address field. The low 11 bits of the word it returns become the operand address. This holds for every opcode.
- R4: Opcode 1 loads ACC with the word at the operand address. Opcode 2 adds that word to ACC modulo 2^16. Opcode 3 sets the interrupt-enable bit. Every other opcode makes no operand read and changes neither ACC nor the enable bit.
- R5: A strobe, once raised, stays high with a stable address until ready is high. The sequencer moves on only on ready. Read and write strobes are never high together.
- R6: The interrupt request is sampled only in the single cycle where instr_done_o is high, and only when the enable bit is 1. At any other time the request has no effect.
- R7: Interrupt entry writes the next-instruction PC to SAVE_ADDR and clears the enable bit. The next fetch reads HANDLER_ADDR.
- R8: With L wait cycles per memory access, one instruction spans L+5 cycles from one instr_done_o pulse to the next. The indirect subcycle adds L+2 cycles, an operand read adds L+1, and a preceding interrupt entry adds L+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 11 | Memory address, driven from the MAR |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the MBR |
| mem_rdata | input | 16 | Read data, valid when ready is high |
| mem_ready | input | 1 | Memory completes the pending access |
| irq | input | 1 | Interrupt request, level |
| instr_done_o | output | 1 | One-cycle pulse at each instruction end |
| pc_o | output | 11 | Program counter |
| acc_o | output | 16 | Accumulator |
| int_en_o | output | 1 | Interrupt-enable bit |

## Verification
Two events can meet at one instruction boundary. The enable-setting opcode takes effect in the same instruction whose end samples the interrupt request. The bench provokes this by holding irq high from reset. The two instructions before the enable must then run with no entry. The enable instruction itself must end in a save write of return address 3, followed by a fetch at the handler. Because irq stays high, the cleared enable bit must also keep every handler instruction from entering again. All of this is judged through the ordered trace of memory accesses and the cycle gaps between instruction ends, swept over several memory latencies.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_LOAD   = 4'd1;
   localparam logic [OPC_W-1:0] OPC_ADD    = 4'd2;
   localparam logic [OPC_W-1:0] OPC_INT_ON = 4'd3;

   typedef enum logic [3:0] {
      ST_F_ADDR,
      ST_F_READ,
      ST_F_DECODE,
      ST_I_ADDR,
      ST_I_READ,
      ST_X_ADDR,
      ST_X_READ,
      ST_BOUNDARY,
      ST_SAVE_WRITE
   } cyc_state_t;

   typedef struct packed {
      logic mar_from_pc;
      logic mar_from_field;
      logic mar_from_save;
      logic mbr_from_mem;
      logic mbr_from_pc;
      logic ir_from_mbr;
      logic pc_step;
      logic pc_from_handler;
      logic acc_load;
      logic acc_add;
      logic ien_set;
      logic ien_clear;
   } xfer_t;

endpackage

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
   import icyc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mem_ready,
   input  logic             irq,
   input  logic             ien,
   input  logic             ind_flag,
   input  logic [OPC_W-1:0] opc,
   output xfer_t            xfer,
   output logic             rd_strobe,
   output logic             wr_strobe,
   output logic             instr_done,
   output logic             fetch_read
);

   cyc_state_t st, st_nxt;
   logic       uses_operand;

   assign uses_operand = (opc == OPC_LOAD) || (opc == OPC_ADD);
   assign fetch_read   = (st == ST_F_READ);

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_F_ADDR;
      else        st <= st_nxt;
   end

   always_comb begin
      xfer       = '0;
      rd_strobe  = 1'b0;
      wr_strobe  = 1'b0;
      instr_done = 1'b0;
      st_nxt     = st;
      case (st)
         ST_F_ADDR: begin
            xfer.mar_from_pc = 1'b1;
            st_nxt = ST_F_READ;
         end
         ST_F_READ: begin
            rd_strobe = 1'b1;
            if (mem_ready) begin
               xfer.mbr_from_mem = 1'b1;
               xfer.pc_step      = 1'b1;
               st_nxt = ST_F_DECODE;
            end
         end
         ST_F_DECODE: begin
            xfer.ir_from_mbr = 1'b1;
            st_nxt = ind_flag ? ST_I_ADDR : ST_X_ADDR;
         end
         ST_I_ADDR: begin
            xfer.mar_from_field = 1'b1;
            st_nxt = ST_I_READ;
         end
         ST_I_READ: begin
            rd_strobe = 1'b1;
            if (mem_ready) begin
               xfer.mbr_from_mem = 1'b1;
               st_nxt = ST_X_ADDR;
            end
         end
         ST_X_ADDR: begin
            if (uses_operand) begin
               xfer.mar_from_field = 1'b1;
               st_nxt = ST_X_READ;
            end else begin
               xfer.ien_set = (opc == OPC_INT_ON);
               st_nxt = ST_BOUNDARY;
            end
         end
         ST_X_READ: begin
            rd_strobe = 1'b1;
            if (mem_ready) begin
               xfer.mbr_from_mem = 1'b1;
               xfer.acc_load     = (opc == OPC_LOAD);
               xfer.acc_add      = (opc == OPC_ADD);
               st_nxt = ST_BOUNDARY;
            end
         end
         ST_BOUNDARY: begin
            instr_done = 1'b1;
            if (ien && irq) begin
               xfer.mbr_from_pc   = 1'b1;
               xfer.mar_from_save = 1'b1;
               xfer.ien_clear     = 1'b1;
               st_nxt = ST_SAVE_WRITE;
            end else begin
               st_nxt = ST_F_ADDR;
            end
         end
         ST_SAVE_WRITE: begin
            wr_strobe = 1'b1;
            if (mem_ready) begin
               xfer.pc_from_handler = 1'b1;
               st_nxt = ST_F_ADDR;
            end
         end
         default: st_nxt = ST_F_ADDR;
      endcase
   end

   // R5: an access left unanswered is still pending in the next cycle
   a_r5_read_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !mem_ready) |=> rd_strobe);
   a_r5_write_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && !mem_ready) |=> wr_strobe);
   // R6: a boundary without a taken entry goes straight back to fetch
   a_r6_boundary_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_done && !(ien && irq)) |=> (st == ST_F_ADDR));

endmodule

// File: rtl/icyc_regs.sv
module icyc_regs
   import icyc_pkg::*;
#(
   parameter int          DATA_W       = 16,
   parameter int          ADDR_W       = 11,
   parameter int unsigned SAVE_ADDR    = 'h0FF,
   parameter int unsigned HANDLER_ADDR = 'h100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xfer_t             xfer,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] mbr,
   output logic [DATA_W-1:0] ir,
   output logic [DATA_W-1:0] acc,
   output logic              ien
);

   localparam int               PAD_W     = DATA_W - ADDR_W;
   localparam logic [ADDR_W-1:0] SAVE_A    = ADDR_W'(SAVE_ADDR);
   localparam logic [ADDR_W-1:0] HANDLER_A = ADDR_W'(HANDLER_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc  <= '0;
         mar <= '0;
         mbr <= '0;
         ir  <= '0;
         acc <= '0;
         ien <= 1'b0;
      end else begin
         if (xfer.pc_step)              pc <= pc + 1'b1;
         else if (xfer.pc_from_handler) pc <= HANDLER_A;

         if (xfer.mar_from_pc)         mar <= pc;
         else if (xfer.mar_from_field) mar <= mbr[ADDR_W-1:0];
         else if (xfer.mar_from_save)  mar <= SAVE_A;

         if (xfer.mbr_from_mem)     mbr <= mem_rdata;
         else if (xfer.mbr_from_pc) mbr <= {{PAD_W{1'b0}}, pc};

         if (xfer.ir_from_mbr) ir <= mbr;

         if (xfer.acc_load)     acc <= mem_rdata;
         else if (xfer.acc_add) acc <= acc + mem_rdata;

         if (xfer.ien_clear)    ien <= 1'b0;
         else if (xfer.ien_set) ien <= 1'b1;
      end
   end

   // R7: the saved word is the PC value of the instruction boundary
   a_r7_saved_pc: assert property (@(posedge clk) disable iff (!rst_n)
      xfer.mbr_from_pc |=> (mbr[ADDR_W-1:0] == $past(pc)));

endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
   import icyc_pkg::*;
#(
   parameter int          DATA_W       = 16,
   parameter int          ADDR_W       = 11,
   parameter int unsigned SAVE_ADDR    = 'h0FF,
   parameter int unsigned HANDLER_ADDR = 'h100
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   input  logic              irq,
   output logic              instr_done_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] acc_o,
   output logic              int_en_o
);

   localparam int IND_BIT = ADDR_W;
   localparam int OPC_LSB = ADDR_W + 1;

   generate
      if (DATA_W != OPC_W + 1 + ADDR_W) begin : g_bad_word
         $error("word width must hold opcode, indirect flag and address field");
      end
      if (SAVE_ADDR >= (1 << ADDR_W) || HANDLER_ADDR >= (1 << ADDR_W)) begin : g_bad_vec
         $error("save and handler addresses must fit the address field");
      end
   endgenerate

   xfer_t             xfer;
   logic [ADDR_W-1:0] pc, mar;
   logic [DATA_W-1:0] mbr, ir, acc;
   logic              ien, fetch_read;

   icyc_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .mem_ready  (mem_ready),
      .irq        (irq),
      .ien        (ien),
      .ind_flag   (mbr[IND_BIT]),
      .opc        (ir[DATA_W-1:OPC_LSB]),
      .xfer       (xfer),
      .rd_strobe  (mem_rd),
      .wr_strobe  (mem_wr),
      .instr_done (instr_done_o),
      .fetch_read (fetch_read)
   );

   icyc_regs #(
      .DATA_W       (DATA_W),
      .ADDR_W       (ADDR_W),
      .SAVE_ADDR    (SAVE_ADDR),
      .HANDLER_ADDR (HANDLER_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .xfer      (xfer),
      .mem_rdata (mem_rdata),
      .pc        (pc),
      .mar       (mar),
      .mbr       (mbr),
      .ir        (ir),
      .acc       (acc),
      .ien       (ien)
   );

   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign pc_o      = pc;
   assign acc_o     = acc;
   assign int_en_o  = ien;

   // R5: strobes exclusive, address stable while waiting
   a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && !mem_ready) |=> $stable(mem_addr));
   // R2: the fetch read goes to the current PC
   a_r2_fetch_at_pc: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_read |-> (mem_addr == pc_o));
   // R6: a write can only start right after an enabled boundary
   a_r6_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr) |-> ($past(instr_done_o) && $past(int_en_o)));
   // R7: the save write targets the fixed location with enable cleared
   a_r7_save_target: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ((mem_addr == ADDR_W'(SAVE_ADDR)) && !int_en_o));
   a_r7_handler_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && mem_ready) |=> (pc_o == ADDR_W'(HANDLER_ADDR)));

endmodule

// File: tb/icyc_seq_tb.sv
`timescale 1ns/1ps
module icyc_seq_tb_top;

   localparam int DW = 16;
   localparam int AW = 11;
   localparam int SAVE = 'h0FF;
   localparam int HAND = 'h100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr, mem_ready, irq, instr_done_o, int_en_o;
   logic [DW-1:0] mem_wdata, mem_rdata, acc_o;
   logic [AW-1:0] pc_o;

   logic [DW-1:0] mem [0:(1<<AW)-1];
   int            lat = 0;
   int            wcnt = 0;
   int            n_total = 0;
   int            n_fail = 0;

   always #2 clk = ~clk;

   icyc_seq #(.DATA_W(DW), .ADDR_W(AW), .SAVE_ADDR(SAVE), .HANDLER_ADDR(HAND)) dut_i (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq),
      .instr_done_o(instr_done_o), .pc_o(pc_o), .acc_o(acc_o), .int_en_o(int_en_o));

   assign mem_rdata = mem[mem_addr];
   assign mem_ready = (mem_rd || mem_wr) && (wcnt == lat);

   always @(posedge clk) begin
      if (!rst_n)                             wcnt <= 0;
      else if ((mem_rd || mem_wr) && !mem_ready) wcnt <= wcnt + 1;
      else                                    wcnt <= 0;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s lat=%0d actual=%h expected=%h", req, lat, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] ins(input int opc, input int ind, input int a);
      return {4'(opc), 1'(ind), 11'(a)};
   endfunction

   task automatic load_prog();
      for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
      mem[0]     = ins(1, 0, 'h040);   // R4 load
      mem[1]     = ins(2, 1, 'h041);   // R3 indirect add
      mem[2]     = ins(3, 0, 'h000);   // R4 enable interrupts
      mem['h100] = ins(2, 0, 'h043);
      mem['h101] = ins(0, 1, 'h044);   // R3 indirect on a no-op
      mem['h102] = ins(2, 0, 'h045);   // R4 wrap
      mem['h040] = 16'h1234;
      mem['h041] = 16'h0042;
      mem['h042] = 16'h0101;
      mem['h043] = 16'h0001;
      mem['h044] = 16'h0777;
      mem['h045] = 16'hFFFF;
   endtask

   task automatic run_case(input int L);
      int exp_gap [6];
      int exp_pc  [6];
      int exp_acc [6];
      int exp_ien [6];
      int exp_log [13];
      int seen    [16];
      int nlog = 0;
      int ndone = 0;
      int last_c = 0;
      rst_n = 1'b0;
      lat = L;
      load_prog();
      exp_gap = '{0, 3*L+8, L+5, 3*L+7, 2*L+7, 2*L+6};
      exp_pc  = '{1, 2, 3, 'h101, 'h102, 'h103};
      exp_acc = '{'h1234, 'h1335, 'h1335, 'h1336, 'h1336, 'h1335};
      exp_ien = '{0, 0, 1, 0, 0, 0};
      exp_log = '{'h000, 'h040, 'h001, 'h041, 'h042, 'h002, 'h80FF,
                  'h100, 'h043, 'h101, 'h044, 'h102, 'h045};
      repeat (3) @(negedge clk);
      chk(pc_o == 0, "R1 pc", int'(pc_o), 0);
      chk(acc_o == 0, "R1 acc", int'(acc_o), 0);
      chk(int_en_o == 0, "R1 enable", int'(int_en_o), 0);
      chk(!mem_rd && !mem_wr, "R1 strobes", int'({mem_rd, mem_wr}), 0);
      rst_n = 1'b1;
      for (int c = 1; c < 500 && ndone < 6; c++) begin
         @(negedge clk);
         if (mem_ready && nlog < 16) begin
            seen[nlog] = mem_wr ? ('h8000 | int'(mem_addr)) : int'(mem_addr);
            nlog++;
            if (mem_wr) chk(mem_wdata == 3, "R7 saved return address", int'(mem_wdata), 3);
         end
         if (instr_done_o) begin
            if (ndone > 0)
               chk(c - last_c == exp_gap[ndone], "R8 cycles per instruction", c - last_c, exp_gap[ndone]);
            chk(int'(pc_o) == exp_pc[ndone], "R2 pc at boundary", int'(pc_o), exp_pc[ndone]);
            chk(int'(acc_o) == exp_acc[ndone], "R4 accumulator", int'(acc_o), exp_acc[ndone]);
            chk(int'(int_en_o) == exp_ien[ndone], "R6 enable bit", int'(int_en_o), exp_ien[ndone]);
            last_c = c;
            ndone++;
         end
      end
      chk(ndone == 6, "R5 progress", ndone, 6);
      chk(nlog == 13, "R3 access count", nlog, 13);
      for (int k = 0; k < 13; k++)
         if (k < nlog) chk(seen[k] == exp_log[k], "R7 access order", seen[k], exp_log[k]);
   endtask

   initial begin
      irq = 1'b1;   // R6: held high from reset, must only act when enabled
      for (int L = 0; L < 4; L++) run_case(L);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule